// File: doc/BRIEF.md
# Completion Packet Register Readout

This block takes inbound completion packets as a stream of 64-bit beats, each marked with start and end flags, and stores them in a small FIFO. Software reads the packets two dwords at a time through memory-mapped registers. One beat at a time sits in a holding stage, and its two halves appear in a pair of data registers. A status register shows whether the beat on display opens or closes a packet, and whether any beat is waiting.

Software drains a packet as follows. It polls the status register until the start bit is 1. It then reads data register 0 and data register 1. Reading data register 1 retires the beat, and the next beat moves into the holding stage. Software checks the end bit of each beat before it retires that beat, so it knows when the packet is finished.

Arrival of a start beat sets an interrupt status bit. Software clears that bit by writing 1 to it. An enable register gates the bit onto a level interrupt output.

Top module: `cpl_readout`

Register map (byte addresses, compared in full):

| Address | Register | Contents |
|---|---|---|
| 0x3070 | data register 0 | bits 31:0 of the held beat |
| 0x3074 | data register 1 | bits 63:32 of the held beat |
| 0x3078 | status | see R4 |
| 0x3060 | interrupt status | bit 4 only |
| 0x3064 | interrupt enable | bit 4 only |

## Requirements
- R1: After reset, status reads 0, interrupt status reads 0, interrupt enable reads 0, `irq` is 0 and `in_ready` is 1.
- R2: When a start beat reaches the front, data register 0 (0x3070) returns `in_data[31:0]` of that beat, which is dword 0. Data register 1 (0x3074) returns `in_data[63:32]`, which is dword 1. The beat is visible two clock edges after it is accepted into an empty block.
- R3: A read of data register 1 retires the held beat, and the next queued beat is shown from the following cycle. A read of data register 0 or of the status register changes nothing.
- R4: The status register (0x3078) has these bits: bit 0 is the start flag of the held beat, bit 1 is its end flag, and bit 2 is 1 while a beat is held or queued. Bits 31:3 read as 0. Beats come out in the order they arrived, with their flags intact.
- R5: When nothing is held, status bits 0 and 1 read 0 and the data registers keep their last values. A read of data register 1 in this state has no effect.
- R6: Accepting a beat with the start flag set raises bit 4 of interrupt status (0x3060). Bits 31:5 and 3:0 read as 0.
- R7: A write to 0x3060 with bit 4 set clears the status bit. A write with bit 4 clear leaves it unchanged.
- R8: If a start beat is accepted in the same cycle as a clearing write, the status bit stays 1.
- R9: Bit 4 of the enable register (0x3064) is readable. `irq` is 1 exactly when both status bit 4 and enable bit 4 are 1.
- R10: With no reads, the block accepts DEPTH+1 beats (the FIFO plus the holding stage) and then holds `in_ready` low. The queued beats then drain in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 64 | Inbound beat; dword 0 in bits 31:0 |
| in_sop | input | 1 | Beat starts a packet |
| in_eop | input | 1 | Beat ends a packet |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 14 | Register read byte address |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 14 | Register write byte address |
| wr_data | input | 32 | Register write data |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples it in the strobe cycle, shortly after driving the address on the falling edge. A retiring read of data register 1 takes effect at the next rising edge, and the following beat is checked from the next strobe onward. An accepted beat appears in the holding stage two rising edges after it is accepted, so the bench waits at least that long before it polls status. Interrupt status and `irq` change one edge after the accepting beat or the clearing write, and the bench checks them on the next falling edge.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
    localparam int DWORD_W = 32;
    localparam int BEAT_W  = 2 * DWORD_W;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BEAT_W-1:0] data;
    } beat_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DAT0,
        SEL_DAT1,
        SEL_STAT,
        SEL_IST,
        SEL_IEN
    } reg_sel_e;
endpackage

// File: rtl/cpl_fifo.sv
module cpl_fifo
    import cpl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  beat_t            push_beat,
    input  logic             pop,
    output beat_t            head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        beat_t [DEPTH-1:0] mem;
        logic [PW-1:0]     wp;
        logic [PW-1:0]     rp;
        logic [CNT_W-1:0]  cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_beat;
            st_d.wp = bump(st_q.wp);
        end
        if (pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
endmodule

// File: rtl/cpl_beat_hold.sv
module cpl_beat_hold
    import cpl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_empty,
    input  beat_t src_head,
    input  logic  retire,
    output logic  take,
    output logic  vld,
    output beat_t cur
);
    typedef struct packed {
        logic  vld;
        beat_t cur;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = !src_empty && (!st_q.vld || retire);
        if (take) begin
            st_d.vld = 1'b1;
            st_d.cur = src_head;
        end else if (retire) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld = st_q.vld;
    assign cur = st_q.cur;
endmodule

// File: rtl/cpl_irq.sv
module cpl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic clr,
    input  logic en_wr,
    input  logic en_val,
    output logic stat,
    output logic ena,
    output logic irq
);
    typedef struct packed {
        logic stat;
        logic ena;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)    st_d.stat = 1'b0;
        if (arrive) st_d.stat = 1'b1;
        if (en_wr)  st_d.ena  = en_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign ena  = st_q.ena;
    assign irq  = st_q.stat & st_q.ena;
endmodule

// File: rtl/cpl_readout.sv
module cpl_readout
    import cpl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 14,
    parameter logic [AW-1:0] A_IST  = 14'h3060,
    parameter logic [AW-1:0] A_IEN  = 14'h3064,
    parameter logic [AW-1:0] A_DAT0 = 14'h3070,
    parameter logic [AW-1:0] A_DAT1 = 14'h3074,
    parameter logic [AW-1:0] A_STAT = 14'h3078,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IRQ_BIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BEAT_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [DWORD_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DWORD_W-1:0] wr_data,
    output logic               irq
);
    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        if      (a == A_DAT0) return SEL_DAT0;
        else if (a == A_DAT1) return SEL_DAT1;
        else if (a == A_STAT) return SEL_STAT;
        else if (a == A_IST)  return SEL_IST;
        else if (a == A_IEN)  return SEL_IEN;
        else                  return SEL_NONE;
    endfunction

    reg_sel_e rsel, wsel;
    logic accept, take, retire, fifo_full, fifo_empty;
    logic hold_vld, ist_q, ien_q;
    logic [BEAT_W-1:0] hold_data;
    logic [CNT_W-1:0] fifo_count;
    beat_t in_beat, head, cur;
    logic unused_wbits;

    assign rsel = rd_en ? decode(rd_addr) : SEL_NONE;
    assign wsel = wr_en ? decode(wr_addr) : SEL_NONE;
    assign unused_wbits = ^{wr_data[DWORD_W-1:IRQ_BIT+1], wr_data[IRQ_BIT-1:0]};

    assign in_ready = !fifo_full;
    assign accept   = in_valid && in_ready;
    assign in_beat  = '{sop: in_sop, eop: in_eop, data: in_data};
    assign retire   = (rsel == SEL_DAT1);

    cpl_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_beat(in_beat), .pop(take),
        .head(head), .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
    );

    cpl_beat_hold u_hold (
        .clk(clk), .rst_n(rst_n),
        .src_empty(fifo_empty), .src_head(head), .retire(retire),
        .take(take), .vld(hold_vld), .cur(cur)
    );

    assign hold_data = cur.data;

    cpl_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .arrive(accept && in_sop),
        .clr((wsel == SEL_IST) && wr_data[IRQ_BIT]),
        .en_wr(wsel == SEL_IEN), .en_val(wr_data[IRQ_BIT]),
        .stat(ist_q), .ena(ien_q), .irq(irq)
    );

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_DAT0: rd_data = cur.data[DWORD_W-1:0];
            SEL_DAT1: rd_data = cur.data[BEAT_W-1:DWORD_W];
            SEL_STAT: rd_data = {{(DWORD_W-3){1'b0}},
                                 hold_vld || !fifo_empty,
                                 hold_vld && cur.eop,
                                 hold_vld && cur.sop};
            SEL_IST:  rd_data[IRQ_BIT] = ist_q;
            SEL_IEN:  rd_data[IRQ_BIT] = ien_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cpl_readout_chk.sv
module cpl_readout_chk #(
    parameter int DEPTH = 8,
    parameter int AW = 14,
    parameter logic [AW-1:0] A_IST  = 14'h3060,
    parameter logic [AW-1:0] A_DAT0 = 14'h3070,
    parameter logic [AW-1:0] A_DAT1 = 14'h3074,
    parameter logic [AW-1:0] A_STAT = 14'h3078,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_sop,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [31:0]      rd_data,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [31:0]      wr_data,
    input logic             irq,
    input logic             hold_vld,
    input logic [63:0]      hold_data,
    input logic [CNT_W-1:0] fifo_count,
    input logic             ist_q,
    input logic             ien_q
);
    p_set_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop) |=> ist_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IST && wr_data[4] && !(in_valid && in_ready && in_sop))
        |=> !ist_q);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IST && wr_data[4] && in_valid && in_ready && in_sop)
        |=> ist_q);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ist_q && ien_q));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    p_dat0_no_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_DAT0 && hold_vld) |=> (hold_vld && $stable(hold_data)));

    p_empty_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_DAT1 && !hold_vld && fifo_count == '0)
        |=> $stable(hold_data));

    p_status_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_STAT) |-> (rd_data[31:3] == '0));
endmodule

bind cpl_readout cpl_readout_chk #(
    .DEPTH(DEPTH), .AW(AW), .A_IST(A_IST),
    .A_DAT0(A_DAT0), .A_DAT1(A_DAT1), .A_STAT(A_STAT)
) u_chk (.*);

// File: tb/tb_cpl_readout.sv
module tb_cpl_readout;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam logic [13:0] IST = 14'h3060, IEN = 14'h3064,
                            D0 = 14'h3070, D1 = 14'h3074, ST = 14'h3078;
    localparam int NV = 6;
    // {sop, eop, data}
    localparam logic [65:0] VEC [NV] = '{
        {1'b1, 1'b0, 64'h1111_0001_AAAA_0000},
        {1'b0, 1'b0, 64'h1111_0003_AAAA_0002},
        {1'b0, 1'b1, 64'h1111_0005_AAAA_0004},
        {1'b1, 1'b1, 64'h2222_0001_BBBB_0000},
        {1'b1, 1'b0, 64'h3333_0001_CCCC_0000},
        {1'b0, 1'b1, 64'h3333_0003_CCCC_0002}
    };

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [63:0] in_data = '0;
    logic rd_en = 0, wr_en = 0;
    logic [13:0] rd_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic in_ready, irq;
    logic [31:0] rd_data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpl_readout dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic push(input logic s, input logic e, input logic [63:0] d);
        @(negedge clk); in_valid = 1; in_sop = s; in_eop = e; in_data = d;
        @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] first_lo;
        int acc;
        do_reset();
        // R1: reset state
        rd(ST, d);  check("R1 status", d, 0);
        rd(IST, d); check("R1 int status", d, 0);
        rd(IEN, d); check("R1 int enable", d, 0);
        check("R1 irq", irq, 0);
        check("R1 in_ready", in_ready, 1);

        // Table walk: push three packets, then drain beat by beat
        for (int i = 0; i < NV; i++) push(VEC[i][65], VEC[i][64], VEC[i][63:0]);
        repeat (2) @(negedge clk);
        rd(IST, d); check("R6 int status on arrival", d, 32'h10);
        check("R9 irq while disabled", irq, 0);
        for (int i = 0; i < NV; i++) begin
            rd(ST, d);
            check("R4 status flags", d, {29'b0, 1'b1, VEC[i][64], VEC[i][65]});
            rd(D0, d); check("R2 dword low", d, VEC[i][31:0]);
            rd(ST, d);
            check("R3 status after data0 read", d, {29'b0, 1'b1, VEC[i][64], VEC[i][65]});
            rd(D0, d); check("R3 data0 repeat", d, VEC[i][31:0]);
            rd(D1, d); check("R2 dword high", d, VEC[i][63:32]);
        end
        // R5: empty state
        rd(ST, d); check("R5 empty status", d, 0);
        rd(D0, d); check("R5 data0 holds last", d, VEC[NV-1][31:0]);
        rd(D1, d); check("R5 data1 holds last", d, VEC[NV-1][63:32]);
        rd(D1, d); check("R5 data1 retire when empty", d, VEC[NV-1][63:32]);
        rd(ST, d); check("R5 status still empty", d, 0);

        // R7/R9: write-one-to-clear and enable gating
        wr(IST, 32'hFFFF_FFEF);
        rd(IST, d); check("R7 write zero to bit4 keeps", d, 32'h10);
        wr(IEN, 32'h10);
        rd(IEN, d); check("R9 enable readback", d, 32'h10);
        check("R9 irq asserted", irq, 1);
        wr(IST, 32'h10);
        rd(IST, d); check("R7 cleared", d, 0);
        check("R9 irq dropped", irq, 0);

        // R8: start beat and clear in the same cycle
        push(1, 1, 64'h4444_0001_DDDD_0000);
        @(negedge clk);
        in_valid = 1; in_sop = 1; in_eop = 1; in_data = 64'h5555_0001_EEEE_0000;
        wr_en = 1; wr_addr = IST; wr_data = 32'h10;
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; wr_en = 0;
        rd(IST, d); check("R8 set wins", d, 32'h10);
        check("R8 irq still set", irq, 1);

        // R10: capacity and order
        do_reset();
        @(negedge clk);
        acc = 0;
        in_valid = 1; in_sop = 1; in_eop = 1; in_data = 64'd0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (in_ready) acc++;
            @(negedge clk);
            in_data = 64'(acc);
        end
        in_valid = 0; in_sop = 0; in_eop = 0;
        check("R10 accepted beats", acc, DEPTH + 1);
        check("R10 in_ready low when full", in_ready, 0);
        first_lo = 0;
        for (int k = 0; k <= DEPTH; k++) begin
            rd(D0, d); check("R10 order", d, 32'(k));
            rd(D1, d);
            first_lo = first_lo + 1;
        end
        check("R10 drained count", first_lo, DEPTH + 1);
        check("R10 in_ready after drain", in_ready, 1);
        rd(ST, d); check("R10 empty after drain", d, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule